// File: doc/BRIEF.md
# Two-Wire Bus Condition Control Register

This block is the 8-bit control and status register of a two-wire serial port. Software uses it to put start and stop conditions on the bus and to force an acknowledge. It also reads back what the bus did. A start or stop request moves a serial-output latch low or high. The block watches the sampled clock (SCL) and data (SDA) lines and raises flags for start, stop and acknowledge events. An acknowledge request pulls the data line low through the next clock-low phase.

The CPU side takes whole-byte writes and single-bit writes. Reads are combinational. The command bits act once and read back as 0. The detection flags are read-only. Each flag has its own set of clear events: a transfer-start strobe, an address-mismatch strobe, port disable, or the opposite bus condition. When a flag's set event and clear event arrive in the same cycle, the set event wins.

Register layout, as read on `rd_data`:

| Bit | Meaning |
|-----|---------|
| 0 | stop command |
| 1 | start command |
| 2 | stop-detected flag |
| 3 | start-detected flag |
| 4 | acknowledge command |
| 5 | acknowledge enable |
| 6 | acknowledge-detected flag |
| 7 | busy enable |

Top module: `tw_cond_ctrl`

## Requirements
- R1: After reset, `rd_data` is 00h, `so_latch` is 1 and `ack_drive` is 0.
- R2: Writing 1 to bit 0 while `port_en` is 1 sets `so_latch` to 1 at the next clock edge. If bit 1 is written in the same write, the stop request wins.
- R3: Writing 1 to bit 1 while `port_en` is 1 (and bit 0 not also written as 1) clears `so_latch` to 0 at the next clock edge.
- R4: While `port_en` is 0, the stop and start commands have no effect, and `so_latch` holds its value.
- R5: An SDA fall while SCL is high sets the start flag (bit 3). After two synchronizer flops, the flag is visible after the third rising clock edge that follows the line change.
- R6: An SDA rise while SCL is high sets the stop flag (bit 2) with the same latency. The same event clears the start flag.
- R7: A `xfer_start` pulse clears the start, stop and acknowledge-detected flags. An `addr_mismatch` pulse clears the stop flag.
- R8: While `port_en` is 0, flags at bits 2, 3 and 6 are held at 0, and bus events do not set them.
- R9: When a flag's set event and one of its clear events occur in the same cycle, the flag ends up set.
- R10: Writing 1 to bit 4 drives `ack_drive` high from the next edge. It stays high through the next synchronized SCL fall. It drops on the first synchronized SCL rise after that fall.
- R11: A `xfer_start` pulse while `port_en` is 0 releases `ack_drive` at the next edge. This takes priority over a simultaneous acknowledge command.
- R12: When bit 5 is 1 and the port is enabled, a synchronized SCL rise with SDA low sets the acknowledge-detected flag (bit 6).
- R13: Bits 0, 1 and 4 always read 0. Writes to bits 2, 3 and 6 are ignored. Bits 5 and 7 store what is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| wr_byte | input | 1 | Full-byte write strobe |
| wr_bit | input | 1 | Single-bit write strobe |
| wr_bit_sel | input | 3 | Bit index for single-bit write |
| wr_bit_val | input | 1 | Value for single-bit write |
| wr_data | input | 8 | Data for full-byte write |
| rd_data | output | 8 | Register read value |
| xfer_start | input | 1 | Transfer-start strobe |
| addr_mismatch | input | 1 | Address-mismatch strobe during address reception |
| scl_in | input | 1 | Sampled clock line |
| sda_in | input | 1 | Sampled data line |
| so_latch | output | 1 | Serial-output latch value |
| ack_drive | output | 1 | High while the data line must be pulled low |

## Verification
CPU writes and strobes take effect at the first rising edge after they are presented. The bench therefore samples one cycle later, on the falling edge. Bus-line results pass through the two synchronizer flops and the edge-detect flop, so they land on the third rising edge after the lines change. Every bus-driven check waits exactly three rising edges and samples on the following falling edge. The set-wins case places the strobe in the one cycle where the synchronized stop event is present, two edges after the SDA change.

// File: rtl/tw_cond_ctrl.sv
module tw_cond_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic       wr_byte,
  input  logic       wr_bit,
  input  logic [2:0] wr_bit_sel,
  input  logic       wr_bit_val,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       xfer_start,
  input  logic       addr_mismatch,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       so_latch,
  output logic       ack_drive
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic stop_det, start_det, ack_det, ack_en, busy_en, ack_fell;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_q  <= scl_sh[SYNC_STAGES-1];
      sda_q  <= sda_sh[SYNC_STAGES-1];
    end

  wire scl_s    = scl_sh[SYNC_STAGES-1];
  wire sda_s    = sda_sh[SYNC_STAGES-1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_ev = port_en & scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = port_en & scl_s & scl_q & ~sda_q & sda_s;
  wire ack_ev   = port_en & ack_en & scl_rise & ~sda_s;

  wire [7:0] wmask = wr_byte ? 8'hFF : (wr_bit ? (8'h01 << wr_bit_sel) : 8'h00);
  wire [7:0] wval  = wr_byte ? wr_data : {8{wr_bit_val}};
  wire [7:0] wset  = wmask & wval;

  wire stop_cmd  = port_en & wset[0];
  wire start_cmd = port_en & wset[1];
  wire ack_cmd   = wset[4];
  wire ack_clr   = xfer_start & ~port_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      so_latch <= 1'b1;
      ack_en   <= 1'b0;
      busy_en  <= 1'b0;
    end else begin
      if (stop_cmd)       so_latch <= 1'b1;
      else if (start_cmd) so_latch <= 1'b0;
      if (wmask[5]) ack_en  <= wval[5];
      if (wmask[7]) busy_en <= wval[7];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stop_det  <= 1'b0;
      start_det <= 1'b0;
      ack_det   <= 1'b0;
    end else begin
      if (stop_ev)                                       stop_det <= 1'b1;
      else if (xfer_start | addr_mismatch | ~port_en)    stop_det <= 1'b0;
      if (start_ev)                                      start_det <= 1'b1;
      else if (xfer_start | stop_ev | ~port_en)          start_det <= 1'b0;
      if (ack_ev)                                        ack_det <= 1'b1;
      else if (xfer_start | ~port_en)                    ack_det <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_drive <= 1'b0;
      ack_fell  <= 1'b0;
    end else if (ack_clr) begin
      ack_drive <= 1'b0;
      ack_fell  <= 1'b0;
    end else if (ack_cmd) begin
      ack_drive <= 1'b1;
      ack_fell  <= 1'b0;
    end else if (ack_drive) begin
      if (scl_fall)
        ack_fell <= 1'b1;
      else if (scl_rise && ack_fell) begin
        ack_drive <= 1'b0;
        ack_fell  <= 1'b0;
      end
    end

  assign rd_data = {busy_en, ack_det, ack_en, 1'b0, start_det, stop_det, 2'b00};

endmodule

module tw_cond_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       wr_byte,
  input logic       wr_bit,
  input logic [2:0] wr_bit_sel,
  input logic       wr_bit_val,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       xfer_start,
  input logic       so_latch,
  input logic       ack_drive
);
  wire stop_wr  = port_en & ((wr_byte & wr_data[0]) |
                  (~wr_byte & wr_bit & (wr_bit_sel == 3'd0) & wr_bit_val));
  wire start_wr = port_en & ((wr_byte & wr_data[1]) |
                  (~wr_byte & wr_bit & (wr_bit_sel == 3'd1) & wr_bit_val));

  a_r2_stop_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> so_latch);
  a_r3_start_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !stop_wr) |=> !so_latch);
  a_r4_latch_held_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(so_latch));
  a_r8_flags_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (rd_data[6] == 1'b0 && rd_data[3:2] == 2'b00));
  a_r11_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !port_en) |=> !ack_drive);
  a_r13_cmd_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b00 && rd_data[4] == 1'b0));
endmodule

bind tw_cond_ctrl tw_cond_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_byte(wr_byte),
  .wr_bit(wr_bit), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
  .wr_data(wr_data), .rd_data(rd_data), .xfer_start(xfer_start),
  .so_latch(so_latch), .ack_drive(ack_drive)
);

// File: tb/tw_cond_ctrl_tb.sv
module tw_cond_ctrl_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic port_en = 0, wr_byte = 0, wr_bit = 0, wr_bit_val = 0;
  logic [2:0] wr_bit_sel = '0;
  logic [7:0] wr_data = '0;
  logic xfer_start = 0, addr_mismatch = 0, scl_in = 1, sda_in = 1;
  logic [7:0] rd_data;
  logic so_latch, ack_drive;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tw_cond_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_byte(wr_byte),
    .wr_bit(wr_bit), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
    .wr_data(wr_data), .rd_data(rd_data), .xfer_start(xfer_start),
    .addr_mismatch(addr_mismatch), .scl_in(scl_in), .sda_in(sda_in),
    .so_latch(so_latch), .ack_drive(ack_drive)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wbyte(input logic [7:0] d);
    wr_byte = 1; wr_data = d;
    @(negedge clk);
    wr_byte = 0;
  endtask

  task automatic wbit(input logic [2:0] s, input logic v);
    wr_bit = 1; wr_bit_sel = s; wr_bit_val = v;
    @(negedge clk);
    wr_bit = 0;
  endtask

  task automatic bus(input logic scl, input logic sda);
    scl_in = scl; sda_in = sda;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_xfer();
    xfer_start = 1; @(negedge clk); xfer_start = 0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 so_latch", so_latch, 1);
    chk("R1 ack_drive", ack_drive, 0);
  endtask

  task automatic t_cmds();
    port_en = 1;
    wbit(3'd1, 1'b1);
    chk("R3 start cmd", so_latch, 0);
    chk("R13 start bit reads 0", rd_data[1], 0);
    wbyte(8'h01);
    chk("R2 stop cmd", so_latch, 1);
    wbyte(8'h03);
    chk("R2 stop wins over start", so_latch, 1);
    port_en = 0;
    wbyte(8'h02);
    chk("R4 start ignored when off", so_latch, 1);
    port_en = 1;
    @(negedge clk);
  endtask

  task automatic t_detect();
    bus(1, 0);
    chk("R5 start flag", rd_data[3], 1);
    pulse_xfer();
    chk("R7 xfer clears start", rd_data[3], 0);
    bus(1, 1);
    chk("R6 stop flag", rd_data[2], 1);
    bus(1, 0);
    chk("R5 start again", rd_data[3], 1);
    bus(1, 1);
    chk("R6 stop clears start", rd_data[3], 0);
    addr_mismatch = 1; @(negedge clk); addr_mismatch = 0;
    chk("R7 mismatch clears stop", rd_data[2], 0);
  endtask

  task automatic t_disable();
    bus(1, 0);
    chk("R5 start before disable", rd_data[3], 1);
    port_en = 0;
    @(negedge clk);
    chk("R8 disable clears flags", rd_data[3:2], 0);
    bus(1, 1);
    chk("R8 stop ignored when off", rd_data[2], 0);
    port_en = 1;
    @(negedge clk);
  endtask

  task automatic t_setwins();
    bus(1, 0);
    sda_in = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    xfer_start = 1;
    @(negedge clk);
    xfer_start = 0;
    chk("R9 stop set beats xfer clear", rd_data[2], 1);
    chk("R6 stop clears start in R9 case", rd_data[3], 0);
  endtask

  task automatic t_ack();
    wbit(3'd4, 1'b1);
    chk("R10 ack drive on", ack_drive, 1);
    chk("R13 ack bit reads 0", rd_data[4], 0);
    repeat (5) @(negedge clk);
    chk("R10 held without fall", ack_drive, 1);
    bus(0, 1);
    chk("R10 held through fall", ack_drive, 1);
    bus(1, 1);
    chk("R10 released on rise", ack_drive, 0);
    wbit(3'd4, 1'b1);
    chk("R10 ack drive again", ack_drive, 1);
    port_en = 0;
    pulse_xfer();
    chk("R11 xfer while off releases", ack_drive, 0);
    port_en = 1;
    @(negedge clk);
  endtask

  task automatic t_ackdet();
    wbyte(8'h20);
    chk("R13 ack enable stored", rd_data[5], 1);
    bus(0, 1);
    bus(0, 0);
    bus(1, 0);
    chk("R12 ack detected", rd_data[6], 1);
    pulse_xfer();
    chk("R7 xfer clears ack flag", rd_data[6], 0);
    bus(0, 0);
    bus(0, 1);
    bus(1, 1);
  endtask

  task automatic t_readonly();
    port_en = 0; @(negedge clk); port_en = 1;
    wbyte(8'hCC);
    chk("R13 flags ignore writes", rd_data, 8'h80);
    wbyte(8'h00);
    chk("R13 cleared", rd_data, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cmds();
    t_detect();
    t_disable();
    t_setwins();
    t_ack();
    t_ackdet();
    t_readonly();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule